// File: doc/BRIEF.md
# T1 Performance Error Counter Bank

This block accumulates line performance statistics for a T1 receiver. Upstream logic delivers single-cycle strobes for four kinds of error: bipolar violations, CRC errors, framing-bit errors and severely errored framing events. A qualifier marks a bipolar violation that is an intentional part of a B8ZS zero substitution, and such a violation is not counted. Each error type has its own counter. The counter widths differ by type, and three of the counters carry a sticky overflow flag.

A control word drives one clear input per counter. Each clear zeroes that counter and its overflow flag. A single group-two interrupt request line reports two kinds of cause: an overflow flag being set, and any increment of the severely errored framing counter. The request stays asserted until it is acknowledged. All counts, flags and the request are plain outputs, and all state updates on the clock edge that samples the strobe.

Top module: `t1_perf_counter_bank`

## Requirements
- R1: Each `bpv_evt_i` strobe adds one to the 8-bit `bpv_cnt_o`. The new value is visible after the same clock edge that samples the strobe.
- R2: A `bpv_evt_i` strobe that arrives with `bpv_b8zs_i` high leaves `bpv_cnt_o`, `bpv_ovf_o` and `g2_irq_o` unchanged.
- R3: Each `crc_evt_i` strobe adds one to the 8-bit `crc_cnt_o`.
- R4: Each `fe_evt_i` strobe adds one to the 4-bit `fe_cnt_o`. Each `se_evt_i` strobe adds one to the 4-bit `se_cnt_o`, and `se_cnt_o` wraps from 15 to 0 with no flag.
- R5: When a counter with an overflow flag takes an event while at its maximum (255 for BPV and CRC, 15 for FE), it wraps to 0 and sets its flag. The flag stays high until that counter's clear is asserted.
- R6: A clear input high at a clock edge sets that counter and its flag to 0 after the edge. This happens even when an event for the same counter arrives in the same cycle.
- R7: When an overflow flag goes from 0 to 1, `g2_irq_o` is high after the same edge. A wrap while the flag is already set raises no new request.
- R8: Every accepted `se_evt_i` strobe raises `g2_irq_o` after the same edge. This includes the wrap from 15 to 0.
- R9: `g2_irq_o` holds high until an edge where `irq_ack_i` is high, and is low after that edge. If a new cause arrives in the same cycle as the acknowledge, the request stays high.
- R10: While `rst_ni` is low, all counts, flags and `g2_irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bpv_evt_i | input | 1 | Bipolar violation strobe |
| bpv_b8zs_i | input | 1 | Marks the current violation as part of a B8ZS substitution |
| crc_evt_i | input | 1 | CRC error strobe |
| fe_evt_i | input | 1 | Framing-bit error strobe |
| se_evt_i | input | 1 | Severely errored framing strobe |
| clr_bpv_i | input | 1 | Clears the BPV count and its flag |
| clr_crc_i | input | 1 | Clears the CRC count and its flag |
| clr_fe_i | input | 1 | Clears the FE count and its flag |
| clr_se_i | input | 1 | Clears the SE count |
| irq_ack_i | input | 1 | Acknowledges the group-two request |
| bpv_cnt_o | output | 8 | BPV count |
| bpv_ovf_o | output | 1 | BPV overflow flag |
| crc_cnt_o | output | 8 | CRC error count |
| crc_ovf_o | output | 1 | CRC overflow flag |
| fe_cnt_o | output | 4 | Framing error count |
| fe_ovf_o | output | 1 | Framing error overflow flag |
| se_cnt_o | output | 4 | Severely errored framing count |
| g2_irq_o | output | 1 | Group-two interrupt request level |

## Verification
Every result of this block is due one clock edge after its stimulus. Counts, flags and the interrupt request all come from registers that load on the edge that samples the strobes, clears and acknowledge, and none of them takes an extra stage. The driver applies each stimulus at a falling edge and records the predicted outputs after the next rising edge. The monitor compares those predictions at the falling edge that follows, so each comparison lands in the first cycle where the result is due and before the next stimulus can change it.

// File: rtl/t1_perf_pkg.sv
package t1_perf_pkg;
  localparam int unsigned NUM_CNT = 4;
  localparam int unsigned MAX_W   = 8;

  typedef enum int unsigned {
    IDX_BPV = 0,
    IDX_CRC = 1,
    IDX_FE  = 2,
    IDX_SE  = 3
  } cnt_idx_e;

  localparam int unsigned CNT_W      [NUM_CNT] = '{8, 8, 4, 4};
  localparam bit          HAS_OVF    [NUM_CNT] = '{1'b1, 1'b1, 1'b1, 1'b0};
  localparam bit          IRQ_ON_INC [NUM_CNT] = '{1'b0, 1'b0, 1'b0, 1'b1};
endpackage

// File: rtl/t1_err_counter.sv
module t1_err_counter #(
  parameter int unsigned W          = 8,
  parameter bit          HAS_OVF    = 1'b1,
  parameter bit          IRQ_ON_INC = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         irq_src_o
);
  logic [W-1:0] cnt_q;
  logic         take;
  logic         at_max;

  assign take   = inc_i & ~clr_i;
  assign at_max = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  generate
    if (HAS_OVF) begin : g_ovf
      logic ovf_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    ovf_q <= 1'b0;
        else if (clr_i)                 ovf_q <= 1'b0;
        else if (inc_i && at_max)       ovf_q <= 1'b1;
      end
      assign ovf_o = ovf_q;
      if (IRQ_ON_INC) begin : g_inc_irq
        assign irq_src_o = take;
      end else begin : g_ovf_irq
        // only the 0->1 transition of the flag is a cause
        assign irq_src_o = take & at_max & ~ovf_q;
      end
    end else begin : g_no_ovf
      assign ovf_o = 1'b0;
      if (IRQ_ON_INC) begin : g_inc_irq
        assign irq_src_o = take;
      end else begin : g_none
        assign irq_src_o = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/t1_g2_irq_latch.sv
module t1_g2_irq_latch #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         ack_i,
  output logic         irq_o
);
  logic pend_q;

  // a fresh cause beats a simultaneous acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (|src_i) pend_q <= 1'b1;
    else if (ack_i)  pend_q <= 1'b0;
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/t1_perf_counter_bank.sv
module t1_perf_counter_bank
  import t1_perf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bpv_evt_i,
  input  logic       bpv_b8zs_i,
  input  logic       crc_evt_i,
  input  logic       fe_evt_i,
  input  logic       se_evt_i,
  input  logic       clr_bpv_i,
  input  logic       clr_crc_i,
  input  logic       clr_fe_i,
  input  logic       clr_se_i,
  input  logic       irq_ack_i,
  output logic [7:0] bpv_cnt_o,
  output logic       bpv_ovf_o,
  output logic [7:0] crc_cnt_o,
  output logic       crc_ovf_o,
  output logic [3:0] fe_cnt_o,
  output logic       fe_ovf_o,
  output logic [3:0] se_cnt_o,
  output logic       g2_irq_o
);
  logic [NUM_CNT-1:0]            inc_vec;
  logic [NUM_CNT-1:0]            clr_vec;
  logic [NUM_CNT-1:0]            src_vec;
  logic [NUM_CNT-2:0]            ovf_vec;
  logic [NUM_CNT-1:0][MAX_W-1:0] cnt_all;

  // B8ZS substitution violations are line coding, not errors
  assign inc_vec[IDX_BPV] = bpv_evt_i & ~bpv_b8zs_i;
  assign inc_vec[IDX_CRC] = crc_evt_i;
  assign inc_vec[IDX_FE]  = fe_evt_i;
  assign inc_vec[IDX_SE]  = se_evt_i;

  assign clr_vec[IDX_BPV] = clr_bpv_i;
  assign clr_vec[IDX_CRC] = clr_crc_i;
  assign clr_vec[IDX_FE]  = clr_fe_i;
  assign clr_vec[IDX_SE]  = clr_se_i;

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      localparam int unsigned W = CNT_W[g];
      logic [W-1:0] cnt_w;
      logic         ovf_w;

      t1_err_counter #(
        .W          (W),
        .HAS_OVF    (HAS_OVF[g]),
        .IRQ_ON_INC (IRQ_ON_INC[g])
      ) i_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (clr_vec[g]),
        .inc_i     (inc_vec[g]),
        .cnt_o     (cnt_w),
        .ovf_o     (ovf_w),
        .irq_src_o (src_vec[g])
      );

      if (W < MAX_W) begin : g_pad
        assign cnt_all[g] = {{(MAX_W-W){1'b0}}, cnt_w};
      end else begin : g_full
        assign cnt_all[g] = cnt_w;
      end

      if (g < NUM_CNT-1) begin : g_ovf_out
        assign ovf_vec[g] = ovf_w;
      end else begin : g_ovf_sink
        logic unused_ovf;
        assign unused_ovf = ovf_w;
      end
    end
  endgenerate

  t1_g2_irq_latch #(.N(NUM_CNT)) i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_vec),
    .ack_i  (irq_ack_i),
    .irq_o  (g2_irq_o)
  );

  logic [3:0] unused_hi;
  assign unused_hi = {cnt_all[IDX_FE][7:6], cnt_all[IDX_SE][7:6]};

  assign bpv_cnt_o = cnt_all[IDX_BPV];
  assign crc_cnt_o = cnt_all[IDX_CRC];
  assign fe_cnt_o  = cnt_all[IDX_FE][3:0];
  assign se_cnt_o  = cnt_all[IDX_SE][3:0];
  assign bpv_ovf_o = ovf_vec[IDX_BPV];
  assign crc_ovf_o = ovf_vec[IDX_CRC];
  assign fe_ovf_o  = ovf_vec[IDX_FE];
endmodule

// File: rtl/t1_perf_counter_bank_sva.sv
module t1_perf_counter_bank_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bpv_evt_i,
  input logic       bpv_b8zs_i,
  input logic       crc_evt_i,
  input logic       fe_evt_i,
  input logic       se_evt_i,
  input logic       clr_bpv_i,
  input logic       clr_crc_i,
  input logic       clr_fe_i,
  input logic       clr_se_i,
  input logic       irq_ack_i,
  input logic [7:0] bpv_cnt_o,
  input logic       bpv_ovf_o,
  input logic [7:0] crc_cnt_o,
  input logic       crc_ovf_o,
  input logic [3:0] fe_cnt_o,
  input logic       fe_ovf_o,
  input logic [3:0] se_cnt_o,
  input logic       g2_irq_o
);
  assert_bpv_inc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bpv_evt_i && !bpv_b8zs_i && !clr_bpv_i |=> bpv_cnt_o == 8'($past(bpv_cnt_o) + 1));

  assert_b8zs_skip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bpv_evt_i && bpv_b8zs_i && !clr_bpv_i |=> $stable(bpv_cnt_o) && $stable(bpv_ovf_o));

  assert_crc_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_evt_i && !clr_crc_i |=> crc_cnt_o == 8'($past(crc_cnt_o) + 1));

  assert_se_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    se_evt_i && !clr_se_i |=> se_cnt_o == 4'($past(se_cnt_o) + 1));

  assert_fe_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_evt_i && !clr_fe_i && fe_cnt_o == 4'hf |=> fe_cnt_o == 4'h0 && fe_ovf_o);

  assert_ovf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_ovf_o && !clr_crc_i |=> crc_ovf_o);

  assert_clr_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_bpv_i |=> bpv_cnt_o == 8'h0 && !bpv_ovf_o);

  assert_ovf_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_ovf_o) |-> g2_irq_o);

  assert_se_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    se_evt_i && !clr_se_i |=> g2_irq_o);

  assert_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i && !bpv_evt_i && !crc_evt_i && !fe_evt_i && !se_evt_i |=> !g2_irq_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g2_irq_o && !irq_ack_i |=> g2_irq_o);
endmodule

bind t1_perf_counter_bank t1_perf_counter_bank_sva i_sva (.*);

// File: tb/test_t1_perf_counter_bank.sv
`timescale 1ns/1ps
module test_t1_perf_counter_bank;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bpv_evt_i = 0, bpv_b8zs_i = 0, crc_evt_i = 0, fe_evt_i = 0, se_evt_i = 0;
  logic       clr_bpv_i = 0, clr_crc_i = 0, clr_fe_i = 0, clr_se_i = 0, irq_ack_i = 0;
  logic [7:0] bpv_cnt_o, crc_cnt_o;
  logic [3:0] fe_cnt_o, se_cnt_o;
  logic       bpv_ovf_o, crc_ovf_o, fe_ovf_o, g2_irq_o;

  always #2.5 clk_i = ~clk_i;

  t1_perf_counter_bank i_t1_perf_counter_bank (.*);

  typedef struct packed {
    logic [7:0] bpv; logic bpvo; logic [7:0] crc; logic crco;
    logic [3:0] fe;  logic feo;  logic [3:0] se;  logic irq;
  } exp_t;

  exp_t  m;
  exp_t  q[$];
  string tq[$];
  int    n_chk = 0, n_bad = 0;
  bit    done = 0;

  task automatic cmp(string req, string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %0d expected %0d", req, tag, act, exp);
    end
  endtask

  // driver: apply at falling edge, predict from requirements, push after rising edge
  task automatic drv(input logic bpv, b8, crc, fe, se, cb, cc, cf, cs, ack, input string tag);
    logic set;
    @(negedge clk_i);
    bpv_evt_i = bpv; bpv_b8zs_i = b8; crc_evt_i = crc; fe_evt_i = fe; se_evt_i = se;
    clr_bpv_i = cb; clr_crc_i = cc; clr_fe_i = cf; clr_se_i = cs; irq_ack_i = ack;
    set = 0;
    if (cb) begin m.bpv = 0; m.bpvo = 0; end
    else if (bpv && !b8) begin
      if (m.bpv == 8'hff) begin if (!m.bpvo) set = 1; m.bpvo = 1; end
      m.bpv = m.bpv + 1;
    end
    if (cc) begin m.crc = 0; m.crco = 0; end
    else if (crc) begin
      if (m.crc == 8'hff) begin if (!m.crco) set = 1; m.crco = 1; end
      m.crc = m.crc + 1;
    end
    if (cf) begin m.fe = 0; m.feo = 0; end
    else if (fe) begin
      if (m.fe == 4'hf) begin if (!m.feo) set = 1; m.feo = 1; end
      m.fe = m.fe + 1;
    end
    if (cs) m.se = 0;
    else if (se) begin m.se = m.se + 1; set = 1; end
    if (set) m.irq = 1; else if (ack) m.irq = 0;
    @(posedge clk_i);
    q.push_back(m);
    tq.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drv(0,0,0,0,0,0,0,0,0,0,tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        exp_t  e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        cmp("R1 bpv_cnt", t, bpv_cnt_o, e.bpv);
        cmp("R5 bpv_ovf", t, bpv_ovf_o, e.bpvo);
        cmp("R3 crc_cnt", t, crc_cnt_o, e.crc);
        cmp("R5 crc_ovf", t, crc_ovf_o, e.crco);
        cmp("R4 fe_cnt",  t, fe_cnt_o,  e.fe);
        cmp("R5 fe_ovf",  t, fe_ovf_o,  e.feo);
        cmp("R4 se_cnt",  t, se_cnt_o,  e.se);
        cmp("R7 g2_irq",  t, g2_irq_o,  e.irq);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m = '0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    cmp("R10", "reset", {bpv_cnt_o, crc_cnt_o, fe_cnt_o, se_cnt_o}, 0);
    cmp("R10", "reset", {bpv_ovf_o, crc_ovf_o, fe_ovf_o, g2_irq_o}, 0);
    rst_ni = 1'b1;
    idle("R10 post-reset");

    // R1 plain BPV counting
    for (int i = 0; i < 5; i++) drv(1,0,0,0,0,0,0,0,0,0,"R1 bpv");
    // R2 B8ZS-flagged violations ignored, interleaved with real ones
    for (int i = 0; i < 4; i++) begin
      drv(1,1,0,0,0,0,0,0,0,0,"R2 b8zs");
      drv(1,0,0,0,0,0,0,0,0,0,"R1 bpv");
    end
    // R3 CRC mixed with others
    for (int i = 0; i < 6; i++) drv(1,0,1,i[0],0,0,0,0,0,0,"R3 mixed");

    // R5/R7 CRC wrap 255->0 raises irq once
    for (int i = 0; i < 250; i++) drv(0,0,1,0,0,0,0,0,0,0,"R5 crc wrap");
    idle("R7 irq hold");
    drv(0,0,0,0,0,0,0,0,0,1,"R9 ack");
    idle("R9 after ack");
    // second wrap with flag set: no new irq
    for (int i = 0; i < 256; i++) drv(0,0,1,0,0,0,0,0,0,0,"R7 second wrap");
    idle("R7 no rearm");

    // R5 FE wrap
    for (int i = 0; i < 16; i++) drv(0,0,0,1,0,0,0,0,0,0,"R5 fe wrap");
    drv(0,0,0,0,0,0,0,0,0,1,"R9 ack fe");
    // R5 BPV wrap
    for (int i = 0; i < 250; i++) drv(1,0,0,0,0,0,0,0,0,0,"R5 bpv wrap");
    drv(1,1,0,0,0,0,0,0,0,1,"R2 b8zs with ack");

    // R8 SE increments, including 15->0 wrap
    for (int i = 0; i < 17; i++) begin
      drv(0,0,0,0,1,0,0,0,0,0,"R8 se inc");
      drv(0,0,0,0,0,0,0,0,0,1,"R8 ack");
    end
    // R9 new cause in the same cycle as ack keeps request
    drv(0,0,0,0,1,0,0,0,0,1,"R9 se with ack");
    idle("R9 hold");
    drv(0,0,0,0,0,0,0,0,0,1,"R9 ack");

    // R6 clear beats simultaneous event
    drv(1,0,1,1,1,1,1,1,1,0,"R6 clear with event");
    idle("R6 after clear");
    for (int i = 0; i < 3; i++) drv(1,0,1,1,1,0,0,0,0,0,"R6 recount");
    drv(0,0,0,0,0,0,1,0,0,1,"R6 crc clear only");
    idle("R6 final");

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule